// File: doc/BRIEF.md
# Event Counter with Threshold Interrupt

This block counts occurrences of one hardware event, picked from a bank of single-cycle event strobes. It raises an interrupt once the count reaches a threshold set by software. The interrupt handler can then note where the program was running. Repeating this over many interrupts gives a statistical profile of which code causes that kind of event.

Software uses a small register interface to set the block up. It chooses the event, writes the threshold, and reads or writes the running count. A control register turns counting on and off, picks the clearing mode and shows the pending interrupt. In automatic mode the count restarts from zero on the threshold edge. In manual mode the count keeps running, and software clears it by writing the count register. The interrupt stays pending until an acknowledge pulse or a write-one-to-clear.

Top module: `evs_threshold_counter`

## Requirements
- R1: After reset, the selection, threshold, count and control registers all read zero, and `irq` is low.
- R2: The count goes up by one at each clock edge where control bit 0 (enable) is set and the strobe of the selected event is high. Strobes of other events have no effect, and nothing is counted while enable is clear.
- R3: When an edge that counts takes the count to a nonzero threshold, the pending flag sets at that edge, and `irq` shows the flag.
- R4: With control bit 1 (automatic mode) set, the edge that reaches the threshold loads zero into the count, not the threshold value.
- R5: With control bit 1 clear, the count keeps going past the threshold, and only a write to the count register brings it back.
- R6: The pending flag stays set until an `irq_ack` pulse, or until a write to the control register with bit 2 set. Writing the control register with bit 2 clear leaves the flag as it is, and further counting does not change it either.
- R7: If the threshold is reached in the same cycle as an acknowledge or a clearing write, the flag stays set.
- R8: A threshold of zero never raises the interrupt, and counting still goes on.
- R9: A write to the count register in a cycle where a counted strobe is also present loads the written value, and that strobe is lost.
- R10: Writing a new event selection does not change the count.
- R11: The register addresses are 0 for selection, 1 for threshold, 2 for count and 3 for control. Read data appears on `bus_rdata` one clock after the address is presented, and control bit 2 reads back the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strobe | input | NUM_EVENTS | One strobe per event source |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_ack | input | 1 | Pulse that clears the pending interrupt |
| irq | output | 1 | Pending interrupt |

## Verification
Two pairs of actions can land in the same clock cycle. The first pair is reaching the threshold and clearing the pending flag. The bench drives the final counted strobe together with `irq_ack` while a flag is already pending, and expects `irq` to stay high while the count returns to zero. The second pair is a counted strobe and a software write to the count register. Here the bench holds the strobe during the write cycle and expects exactly the written value to be read back.

// File: rtl/evs_pkg.sv
package evs_pkg;
  typedef enum logic [1:0] {
    EVS_SEL   = 2'd0,
    EVS_LIMIT = 2'd1,
    EVS_COUNT = 2'd2,
    EVS_CTRL  = 2'd3
  } evs_reg_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_AUTO = 1;
  localparam int CTRL_PEND = 2;
endpackage

// File: rtl/evs_event_pick.sv
module evs_event_pick #(
  parameter int NUM_EVENTS = 8,
  parameter int SEL_W      = 3
) (
  input  logic [NUM_EVENTS-1:0] strobes,
  input  logic [SEL_W-1:0]      sel,
  output logic                  picked
);
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (sel == SEL_W'(i)) picked = strobes[i];
    end
  end
endmodule

// File: rtl/evs_count_core.sv
module evs_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  input  logic             auto_mode,
  output logic [CNT_W-1:0] count,
  output logic             reached
);
  logic [CNT_W-1:0] next_val;

  assign next_val = count + CNT_W'(1);
  // a software load takes priority, so a strobe that comes with it cannot reach the limit
  assign reached  = step && !load && (limit != '0) && (next_val == limit);

  always_ff @(posedge clk) begin
    if (rst)                        count <= '0;
    else if (load)                  count <= load_val;
    else if (reached && auto_mode)  count <= '0;
    else if (step)                  count <= next_val;
  end
endmodule

// File: rtl/evs_pend_flag.sv
module evs_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/evs_threshold_counter.sv
module evs_threshold_counter #(
  parameter int NUM_EVENTS = 8,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] ev_strobe,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  irq_ack,
  output logic                  irq
);
  import evs_pkg::*;

  localparam int SEL_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  evs_reg_e         reg_id;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count_q;
  logic             en_q, auto_q, pend_q;
  logic             picked, reached;
  logic             wr_sel, wr_limit, wr_count, wr_ctrl;
  logic             unused_wdata;

  assign reg_id   = evs_reg_e'(bus_addr);
  assign wr_sel   = bus_wr && (reg_id == EVS_SEL);
  assign wr_limit = bus_wr && (reg_id == EVS_LIMIT);
  assign wr_count = bus_wr && (reg_id == EVS_COUNT);
  assign wr_ctrl  = bus_wr && (reg_id == EVS_CTRL);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      limit_q <= '0;
      en_q    <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      if (wr_sel)   sel_q   <= bus_wdata[SEL_W-1:0];
      if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        en_q   <= bus_wdata[CTRL_EN];
        auto_q <= bus_wdata[CTRL_AUTO];
      end
    end
  end

  evs_event_pick #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_pick (
    .strobes(ev_strobe), .sel(sel_q), .picked(picked)
  );

  evs_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .step(picked && en_q), .load(wr_count),
    .load_val(bus_wdata[CNT_W-1:0]), .limit(limit_q), .auto_mode(auto_q),
    .count(count_q), .reached(reached)
  );

  evs_pend_flag u_pend (
    .clk(clk), .rst(rst), .set(reached),
    .clr(irq_ack || (wr_ctrl && bus_wdata[CTRL_PEND])), .q(pend_q)
  );

  assign irq = pend_q;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (reg_id)
        EVS_SEL:   bus_rdata <= DATA_W'(sel_q);
        EVS_LIMIT: bus_rdata <= DATA_W'(limit_q);
        EVS_COUNT: bus_rdata <= DATA_W'(count_q);
        EVS_CTRL:  bus_rdata <= DATA_W'({pend_q, auto_q, en_q});
      endcase
    end
  end
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              irq_ack,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  limit,
  input logic              reached,
  input logic              auto_mode
);
  logic ctrl_clear, count_write;
  assign ctrl_clear  = bus_wr && (bus_addr == 2'd3) && bus_wdata[2];
  assign count_write = bus_wr && (bus_addr == 2'd2);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!count_write && !reached) |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));
  p_auto_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (reached && auto_mode && !count_write) |=> (count == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack && !ctrl_clear) |=> irq);
  p_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !reached) |=> !irq);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    reached |=> irq);
  p_zero_limit_r8: assert property (@(posedge clk) disable iff (rst)
    (limit == '0 && !irq) |=> !irq);
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    count_write |=> (count == $past(bus_wdata[CNT_W-1:0])));
endmodule

bind evs_threshold_counter evs_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_ack(irq_ack), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count_q), .limit(limit_q),
  .reached(reached), .auto_mode(auto_q)
);

// File: tb/sim_evs_threshold_counter.sv
`timescale 1ns/1ps
module sim_evs_threshold_counter;
  localparam int NE = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic [NE-1:0] ev_strobe = '0;
  logic bus_wr = 1'b0, irq_ack = 1'b0, irq;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evs_threshold_counter #(.NUM_EVENTS(NE), .CNT_W(16), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .ev_strobe(ev_strobe), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(int idx, int n);
    @(negedge clk); ev_strobe[idx] = 1'b1;
    repeat (n) @(negedge clk);
    ev_strobe[idx] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1/R11 reg", v, 0);
    end
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(0, 3); wr(3, 1);
    pulse(3, 5); pulse(2, 3);
    rd(2, v); chk("R2 selected only", v, 5);
    wr(3, 0); pulse(3, 2);
    rd(2, v); chk("R2 disabled", v, 5);
    rd(0, v); chk("R11 sel readback", v, 3);
  endtask

  task automatic t_select_keep();
    logic [31:0] v;
    wr(0, 2);
    rd(2, v); chk("R10 count kept", v, 5);
    wr(3, 1); pulse(2, 2);
    rd(2, v); chk("R10 new source", v, 7);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    wr(2, 0); wr(1, 4); wr(3, 3);
    pulse(2, 3);
    chk("R3 below limit", {31'd0, irq}, 0);
    pulse(2, 1);
    chk("R3 irq raised", {31'd0, irq}, 1);
    rd(2, v); chk("R4 auto restart", v, 0);
    rd(3, v); chk("R11 ctrl pend bit", v, 7);
    pulse(2, 2);
    chk("R6 sticky while counting", {31'd0, irq}, 1);
    rd(2, v); chk("R4 counting resumed", v, 2);
    wr(3, 3);
    chk("R6 bit2 zero keeps", {31'd0, irq}, 1);
    wr(3, 7);
    chk("R6 w1c", {31'd0, irq}, 0);
  endtask

  task automatic t_manual();
    logic [31:0] v;
    wr(2, 0); wr(1, 3); wr(3, 1);
    pulse(2, 3);
    chk("R3 manual irq", {31'd0, irq}, 1);
    rd(2, v); chk("R5 holds at limit", v, 3);
    pulse(2, 2);
    rd(2, v); chk("R5 past limit", v, 5);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R6 ack clears", {31'd0, irq}, 0);
    wr(2, 0);
    rd(2, v); chk("R5 software clear", v, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(1, 3); wr(3, 3);
    pulse(2, 3);
    chk("R7 setup pending", {31'd0, irq}, 1);
    pulse(2, 2);
    @(negedge clk); ev_strobe[2] = 1'b1; irq_ack = 1'b1;
    @(negedge clk); ev_strobe[2] = 1'b0; irq_ack = 1'b0;
    chk("R7 set beats ack", {31'd0, irq}, 1);
    rd(2, v); chk("R7 count restarted", v, 0);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R7 later ack", {31'd0, irq}, 0);
  endtask

  task automatic t_zero_limit();
    logic [31:0] v;
    wr(1, 0); wr(2, 0); wr(3, 3);
    pulse(2, 10);
    chk("R8 no irq", {31'd0, irq}, 0);
    rd(2, v); chk("R8 counts on", v, 10);
  endtask

  task automatic t_load_wins();
    logic [31:0] v;
    @(negedge clk); ev_strobe[2] = 1'b1; bus_wr = 1'b1; bus_addr = 2; bus_wdata = 100;
    @(negedge clk); ev_strobe[2] = 1'b0; bus_wr = 1'b0;
    rd(2, v); chk("R9 write wins", v, 100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset(); t_count(); t_select_keep(); t_auto();
    t_manual(); t_set_wins(); t_zero_limit(); t_load_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule